// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block models a serial EEPROM that answers on a two-wire bus. It runs on a fast system clock and samples the clock line and the data line through synchronisers. It pulls the data line low through a single open-drain enable. The storage is an internal byte array of `2**ADDR_W` bytes. The most significant address bit selects one of two halves. A bit in the control byte chooses that half, and two strap inputs give the target its bus identity.

A master writes by sending a control byte with R/W=0, then two word-address bytes, then one or more data bytes, and ends with a Stop. The bytes land in a page staging buffer. They reach the array only when a timed write cycle of `WR_CYCLES` clocks finishes. The cycle starts at the Stop. While it runs, every control byte goes unacknowledged, so a master can poll for completion.

A master reads by sending a control byte with R/W=1. The read starts from the internal pointer, and a random read loads that pointer first with an address-only write phase. Each master ACK makes the target send the next byte. A NACK ends the read. The pointer stays inside its half of the array.

The state machine has these states. `ST_IDLE` waits for a Start. `ST_CTRL`, `ST_ADDR_HI`, `ST_ADDR_LO` and `ST_WDATA` shift in a byte. `ST_ACK` holds the line low for the ninth clock. `ST_RDATA` shifts a byte out. `ST_RACK` samples the master's acknowledge.

The transitions are as follows.
- A Start from any state goes to `ST_CTRL`, and a Stop from any state goes to `ST_IDLE`.
- From `ST_CTRL`, a matching control byte goes to `ST_ACK` while the target is not busy. Any other control byte goes to `ST_IDLE`.
- Each completed receive byte goes to `ST_ACK`.
- `ST_ACK` returns to the state stored for after the acknowledge:
  - `ST_ADDR_HI` after a write control byte,
  - `ST_ADDR_LO` after the high address byte,
  - `ST_WDATA` after the low address byte or a data byte,
  - `ST_RDATA` after a read control byte.
- `ST_RDATA` goes to `ST_RACK` after eight bits.
- `ST_RACK` goes back to `ST_RDATA` on a master ACK, or to `ST_IDLE` on a NACK.

Top module: `ee_i2c_target`

## Requirements
- R1: The control byte is decoded MSB first. Bits 7..4 must be 1010 and bits 3..2 must equal `strap[1:0]`. Bit 1 is the half-select bit and bit 0 is R/W, where 1 means read. Any other control byte gets no ACK, and the target ignores the bus until the next Start.
- R2: A write transfer stores its data byte at the given address once the write cycle completes. The transfer is a matching control byte with R/W=0, address high byte, address low byte and a data byte, ended by a Stop. Each of those four bytes is acknowledged.
- R3: A write transfer may carry any number of data bytes. Successive bytes advance only the low `PAGE_W` (7) address bits, so bytes past 128 wrap and overwrite earlier bytes of the same page.
- R4: A Stop that ends a transfer with at least one complete data byte starts a busy period of `WR_CYCLES` clocks. During that period no control byte of either direction is acknowledged. Once the period ends, a control byte is acknowledged again.
- R5: A read control byte without a preceding address phase returns the byte at the internal pointer. The pointer holds the address after the last byte read or written.
- R6: A random read returns the byte at the given address. It is an address-only write phase, then a repeated Start, then a read control byte.
- R7: In a read, a master ACK after a byte makes the target send the next address's byte. A NACK ends the read, and the target releases the line.
- R8: The read pointer wraps within its half. The top word address in half 0 is followed by word 0 of half 0, and the top word address in half 1 is followed by word 0 of half 1.
- R9: The half-select bit of the control byte picks the half. The same word address in the two halves names two independent bytes.
- R10: A Start or a Stop arriving in the middle of a byte abandons that byte. A partial data byte is never written and starts no busy period, and a Start mid-byte begins a fresh control byte.
- R11: The data-line enable is low after reset. The enable changes only while the synchronised clock line is low, or in the cycle after a Start or a Stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| strap | input | 2 | Bus identity compared with control byte bits 3..2 |
| scl_in | input | 1 | Bus clock line as seen on the pin |
| sda_in | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | Pulls the data line low when 1 |

## Verification
The end of a write cycle and the decision on a polling control byte can fall close together or in the same cycle. In that case the busy flag and the acknowledge logic meet on one edge. The bench provokes this with acknowledge polling that begins right after each write's Stop. It judges the result three ways:
- the first poll must be refused,
- a later poll must be accepted,
- every byte read back afterwards must equal the staged value and never a half-written mix.

A second overlap is a Stop ending a page write whose data wrapped inside the page. This is judged by reading back the bytes on both sides of the page boundary.

// File: rtl/ee_pkg.sv
package ee_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK
    } ee_state_t;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/ee_line_cond.sv
module ee_line_cond #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic [SYNC_N-1:0] scl_sr, sda_sr;
    logic              scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sr <= '1;
            sda_sr <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sr <= {scl_sr[SYNC_N-2:0], scl_i};
            sda_sr <= {sda_sr[SYNC_N-2:0], sda_i};
            scl_q  <= scl_sr[SYNC_N-1];
            sda_q  <= sda_sr[SYNC_N-1];
        end
    end

    assign scl_s    = scl_sr[SYNC_N-1];
    assign sda_s    = sda_sr[SYNC_N-1];
    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    // data edges while the clock line stays high
    assign start_p  = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_p   = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/ee_store.sv
module ee_store #(
    parameter int ADDR_W    = 10,
    parameter int PAGE_W    = 7,
    parameter int WR_CYCLES = 1000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data,
    input  logic                     stg_clr,
    input  logic                     stg_we,
    input  logic [PAGE_W-1:0]        stg_idx,
    input  logic [7:0]               stg_data,
    input  logic [ADDR_W-PAGE_W-1:0] page_base,
    input  logic                     commit,
    output logic                     busy
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int PAGE   = 1 << PAGE_W;
    localparam int BASE_W = ADDR_W - PAGE_W;
    localparam int TW     = $clog2(WR_CYCLES + 1);

    logic [7:0]        mem [DEPTH];
    logic [7:0]        stg [PAGE];
    logic [PAGE-1:0]   stg_vld;
    logic [BASE_W-1:0] base_q;
    logic [TW-1:0]     timer;

    always_ff @(posedge clk) begin
        if (stg_we) stg[stg_idx] <= stg_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
            stg_vld <= '0;
            base_q  <= '0;
            timer   <= '0;
            busy    <= 1'b0;
        end else begin
            if (stg_clr) stg_vld <= '0;
            if (stg_we)  stg_vld[stg_idx] <= 1'b1;
            if (commit && !busy) begin
                busy   <= 1'b1;
                timer  <= TW'(WR_CYCLES);
                base_q <= page_base;
            end else if (busy) begin
                timer <= timer - 1'b1;
                if (timer == TW'(1)) begin
                    busy <= 1'b0;
                    for (int i = 0; i < PAGE; i++)
                        if (stg_vld[i]) mem[{base_q, PAGE_W'(i)}] <= stg[i];
                    stg_vld <= '0;
                end
            end
        end
    end

    assign rd_data = mem[rd_addr];

    // R4: a Stop after staged data always opens a busy period
    a_r4_busy_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !busy) |=> busy);

    // R2: the front end never stages bytes while the array is busy
    a_r2_no_stage_busy: assert property (@(posedge clk) disable iff (!rst_n)
        stg_we |-> !busy);

endmodule

// File: rtl/ee_i2c_target.sv
module ee_i2c_target
    import ee_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int PAGE_W    = 7,
    parameter int WR_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] strap,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe
);
    localparam int WORD_W = ADDR_W - 1;
    localparam int BASE_W = ADDR_W - PAGE_W;

    ee_state_t         state, ack_ret;
    logic [3:0]        bit_cnt;
    logic [7:0]        sh;
    logic [7:0]        addr_hi;
    logic              blk;
    logic              mack;
    logic              wr_pend;
    logic [ADDR_W-1:0] ptr, ptr_inc;
    logic [15:0]       addr16;
    logic [7:0]        rd_data;
    logic              busy;
    logic              scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic              byte_done, bus_evt, ctrl_hit;
    logic              stg_we, stg_clr, commit;

    ee_line_cond #(.SYNC_N(2)) u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_in),
        .sda_i    (sda_in),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    ee_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr   (ptr),
        .rd_data   (rd_data),
        .stg_clr   (stg_clr),
        .stg_we    (stg_we),
        .stg_idx   (ptr[PAGE_W-1:0]),
        .stg_data  (sh),
        .page_base (ptr[ADDR_W-1:PAGE_W]),
        .commit    (commit),
        .busy      (busy)
    );

    assign byte_done = scl_fall && (bit_cnt == 4'd8);
    assign bus_evt   = start_p || stop_p;
    assign ctrl_hit  = (sh[7:4] == DEV_TYPE) && (sh[3:2] == strap);
    assign addr16    = {addr_hi, sh};
    assign ptr_inc   = {ptr[ADDR_W-1], ptr[WORD_W-1:0] + WORD_W'(1)};

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ack_ret <= ST_IDLE;
            bit_cnt <= '0;
            sh      <= '0;
            addr_hi <= '0;
            blk     <= 1'b0;
            mack    <= 1'b0;
            wr_pend <= 1'b0;
            ptr     <= '0;
        end else if (start_p) begin
            state   <= ST_CTRL;
            bit_cnt <= '0;
            wr_pend <= 1'b0;
        end else if (stop_p) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            wr_pend <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_CTRL, ST_ADDR_HI, ST_ADDR_LO, ST_WDATA: begin
                    if (scl_rise && bit_cnt < 4'd8) begin
                        sh      <= {sh[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (byte_done) begin
                        bit_cnt <= '0;
                        state   <= ST_ACK;
                        if (state == ST_CTRL) begin
                            if (ctrl_hit && !busy) begin
                                blk     <= sh[1];
                                ack_ret <= sh[0] ? ST_RDATA : ST_ADDR_HI;
                                if (sh[0]) ptr[ADDR_W-1] <= sh[1];
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (state == ST_ADDR_HI) begin
                            addr_hi <= sh;
                            ack_ret <= ST_ADDR_LO;
                        end else if (state == ST_ADDR_LO) begin
                            ptr     <= {blk, addr16[WORD_W-1:0]};
                            ack_ret <= ST_WDATA;
                        end else begin
                            ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + PAGE_W'(1);
                            wr_pend         <= 1'b1;
                            ack_ret         <= ST_WDATA;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        state   <= ack_ret;
                        bit_cnt <= '0;
                        if (ack_ret == ST_RDATA) begin
                            sh  <= rd_data;
                            ptr <= ptr_inc;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        sh <= {sh[6:0], 1'b0};
                        if (bit_cnt == 4'd7) begin
                            state   <= ST_RACK;
                            bit_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) mack <= !sda_s;
                    if (scl_fall) begin
                        if (mack) begin
                            state <= ST_RDATA;
                            sh    <= rd_data;
                            ptr   <= ptr_inc;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe  = 1'b0;
        stg_we  = 1'b0;
        stg_clr = 1'b0;
        commit  = stop_p && wr_pend;
        unique case (state)
            ST_ACK:   sda_oe = 1'b1;
            ST_RDATA: sda_oe = !sh[7];
            default:  sda_oe = 1'b0;
        endcase
        if (byte_done && !bus_evt) begin
            if (state == ST_ADDR_LO) stg_clr = 1'b1;
            if (state == ST_WDATA)   stg_we  = 1'b1;
        end
    end

    // R1: a wrong device type is never acknowledged
    a_r1_bad_type_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CTRL && byte_done && !bus_evt && sh[7:4] != DEV_TYPE) |=> !sda_oe);

    // R4: a control byte decided while busy drops to idle
    a_r4_busy_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CTRL && byte_done && !bus_evt && busy) |=> state == ST_IDLE);

    // R3: a data byte never moves the pointer out of its page
    a_r3_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA && byte_done && !bus_evt)
        |=> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));

    // R8: a sequential read stays in its half
    a_r8_half_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RACK && scl_fall && mack && !bus_evt)
        |=> ptr[ADDR_W-1] == $past(ptr[ADDR_W-1]));

    // R11: the line enable moves only with the clock line low
    a_r11_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> (!scl_s || $past(start_p || stop_p)));

endmodule

// File: tb/ee_i2c_target_tb.sv
module ee_i2c_target_tb;

    localparam int Q    = 8;
    localparam int WDOG = 190000;
    localparam logic [1:0] STRAP = 2'b10;

    // kind(2) blk(1) word(16) data(8): kind 0 write, 1 random read, 2 current read
    localparam logic [26:0] VEC [12] = '{
        {2'd0, 1'b1, 16'h0005, 8'hA5},
        {2'd0, 1'b0, 16'h0005, 8'h5A},
        {2'd1, 1'b1, 16'h0005, 8'hA5},
        {2'd1, 1'b0, 16'h0005, 8'h5A},
        {2'd1, 1'b0, 16'h0004, 8'hFF},
        {2'd2, 1'b0, 16'h0000, 8'h5A},
        {2'd2, 1'b0, 16'h0000, 8'hFF},
        {2'd0, 1'b0, 16'h01FF, 8'h33},
        {2'd0, 1'b0, 16'h0000, 8'h22},
        {2'd0, 1'b1, 16'h01FF, 8'h77},
        {2'd0, 1'b1, 16'h0000, 8'h11},
        {2'd1, 1'b1, 16'h0010, 8'hFF}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic dut_oe;
    logic sda_line;
    int   n_chk = 0;
    int   n_fail = 0;

    always #2 clk = ~clk;
    assign sda_line = m_sda & ~dut_oe;

    ee_i2c_target u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .strap  (STRAP),
        .scl_in (m_scl),
        .sda_in (sda_line),
        .sda_oe (dut_oe)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; qwait();
        m_scl = 1'b1; qwait();
        m_sda = 1'b0; qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qwait();
        m_scl = 1'b1; qwait();
        m_sda = 1'b1; qwait();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b;    qwait();
        m_scl = 1'b1; qwait(); qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; qwait();
        m_scl = 1'b1; qwait();
        b = sda_line; qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = !b;
    endtask

    task automatic recv_byte(input logic master_ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(!master_ack);
    endtask

    function automatic logic [7:0] ctrl(input logic blk, input logic rw);
        return {4'b1010, STRAP, blk, rw};
    endfunction

    task automatic set_addr(input logic blk, input logic [15:0] word);
        logic ack;
        bus_start();
        send_byte(ctrl(blk, 1'b0), ack); chk("R2 ctrl ack", {7'd0, ack}, 8'd1);
        send_byte(word[15:8], ack);      chk("R2 addr hi ack", {7'd0, ack}, 8'd1);
        send_byte(word[7:0], ack);       chk("R2 addr lo ack", {7'd0, ack}, 8'd1);
    endtask

    task automatic poll(input logic rw, output logic ack);
        bus_start();
        send_byte(ctrl(1'b0, rw), ack);
        bus_stop();
    endtask

    // R4: first poll right after the Stop is refused, a later one accepted
    task automatic wait_ready();
        logic ack;
        int   tries;
        poll(1'b0, ack);
        chk("R4 busy poll nack", {7'd0, ack}, 8'd0);
        tries = 0;
        while (!ack && tries < 40) begin
            poll(1'b0, ack);
            tries++;
        end
        chk("R4 ready poll ack", {7'd0, ack}, 8'd1);
    endtask

    task automatic byte_write(input logic blk, input logic [15:0] word, input logic [7:0] d);
        logic ack;
        set_addr(blk, word);
        send_byte(d, ack); chk("R2 data ack", {7'd0, ack}, 8'd1);
        bus_stop();
        wait_ready();
    endtask

    task automatic read_check(input string tag, input logic random, input logic blk,
                              input logic [15:0] word, input int n,
                              input logic [7:0] e0, input logic [7:0] e1, input logic [7:0] e2);
        logic       ack;
        logic [7:0] d;
        logic [7:0] exp_v [3];
        exp_v = '{e0, e1, e2};
        if (random) set_addr(blk, word);
        bus_start();
        send_byte(ctrl(blk, 1'b1), ack);
        chk({tag, " read ctrl ack"}, {7'd0, ack}, 8'd1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, d);
            chk(tag, d, exp_v[k]);
        end
        chk("R7 line released after nack", {7'd0, sda_line}, 8'd1);
        bus_stop();
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic       ack;
        logic [7:0] d;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R11 reset oe low", {7'd0, dut_oe}, 8'd0);

        // vector walk: R2 R5 R6 R9
        for (int v = 0; v < 12; v++) begin
            case (VEC[v][26:25])
                2'd0: byte_write(VEC[v][24], VEC[v][23:8], VEC[v][7:0]);
                2'd1: read_check("R6 R9 random read", 1'b1, VEC[v][24], VEC[v][23:8], 1,
                                 VEC[v][7:0], 8'h00, 8'h00);
                default: read_check("R5 current read", 1'b0, VEC[v][24], 16'h0, 1,
                                    VEC[v][7:0], 8'h00, 8'h00);
            endcase
        end

        // R8 and R7: sequential read wraps within each half
        read_check("R8 R7 half0 wrap", 1'b1, 1'b0, 16'h01FF, 2, 8'h33, 8'h22, 8'h00);
        read_check("R8 R7 half1 wrap", 1'b1, 1'b1, 16'h01FF, 2, 8'h77, 8'h11, 8'h00);
        read_check("R5 current after wrap", 1'b0, 1'b1, 16'h0, 1, 8'hFF, 8'h00, 8'h00);

        // R1: strap mismatch and wrong device type get no ACK
        bus_start();
        send_byte({4'b1010, 2'b01, 1'b0, 1'b0}, ack);
        chk("R1 strap mismatch nack", {7'd0, ack}, 8'd0);
        bus_stop();
        bus_start();
        send_byte({4'b1011, STRAP, 1'b0, 1'b0}, ack);
        chk("R1 device type nack", {7'd0, ack}, 8'd0);
        bus_stop();

        // R3: 130-byte page write from offset 7E wraps inside the page
        set_addr(1'b0, 16'h00FE);
        for (int i = 0; i < 130; i++) begin
            send_byte(8'h40 + 8'(i), ack);
            if (i == 0 || i == 129) chk("R3 page data ack", {7'd0, ack}, 8'd1);
        end
        bus_stop();
        poll(1'b1, ack);
        chk("R4 busy read ctrl nack", {7'd0, ack}, 8'd0);
        wait_ready();
        read_check("R3 page tail wrap", 1'b1, 1'b0, 16'h00FE, 3, 8'hC0, 8'hC1, 8'hFF);
        read_check("R3 page head", 1'b1, 1'b0, 16'h0080, 1, 8'h42, 8'h00, 8'h00);
        read_check("R3 page mid", 1'b1, 1'b0, 16'h00FD, 1, 8'hBF, 8'h00, 8'h00);

        // R10: Stop in the middle of a data byte
        set_addr(1'b0, 16'h0040);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop();
        poll(1'b0, ack);
        chk("R10 no busy after partial byte", {7'd0, ack}, 8'd1);
        read_check("R10 partial not written", 1'b1, 1'b0, 16'h0040, 1, 8'hFF, 8'h00, 8'h00);

        // R10: Start in the middle of a control byte restarts decoding
        bus_start();
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        read_check("R10 restart then current read", 1'b0, 1'b0, 16'h0, 1, 8'hFF, 8'h00, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule